// File: doc/BRIEF.md
# Oscillator Enable and Stabilization Controller

This block controls three clock sources of a small microcontroller: an internal oscillator, a low-speed oscillator and a high-speed oscillator. Software turns each source on or off through a byte-wide register port. Each source has a ready flag that the system clock switcher uses. The flag rises only after a stabilization wait has finished, and that wait is counted on the source's own clock. For a source fed by an external clock that is already stable, software can skip the wait.

The ready flag is formed in the source's clock domain. It then reaches the system domain through a two-flop synchronizer. There it drives the `src_ready` outputs and a read-only status register. The block has a guard against stopping the running clock: a write that would turn off the source currently selected as the system clock leaves that source's enable bit set.

Register map (2-bit address). Address 0 is the enable register: bit 0 internal, bit 1 low-speed, bit 2 high-speed. Address 1 is the wait-enable register. Address 2 is the high-speed wait select, in bits 1:0. Address 3 is the status register, which is read-only. All unused bits read 0.

Top module: `clk_src_ctrl`

## Requirements
- R1: After reset, the enable register reads internal=1, low-speed=0 and high-speed=`HI_ON_RST` (default 1). The wait-enable register reads 0x30 and the wait select reads 0.
- R2: `sys_sel` encodes the selected source: 0 internal, 1 low-speed, 2 high-speed, 3 none. On a write to address 0 with `sys_sel` in 0..2, the enable bit of the selected source cannot go from 1 to 0. Every other enable bit takes the written value.
- R3: While `sys_sel` is 3, a write to address 0 loads all three enable bits from `reg_wdata[2:0]` without restriction.
- R4: With the low-speed wait enabled, the low-speed ready flag rises only after `LO_WAIT` low-speed clock cycles have been counted following the enable.
- R5: With the high-speed wait enabled, the wait lasts `HI_WAIT_BASE >> sel` high-speed cycles, where sel is the 2-bit wait select. For a base of 1024, the values 0/1/2/3 give 1024/512/256/128.
- R6: When a source's wait-enable bit is 0, its ready flag rises after the synchronizer delay alone, with no stabilization count.
- R7: Clearing an enable bit drops that source's ready flag after the synchronizer delay and clears its count. Setting the bit again restarts the full wait.
- R8: In the wait-enable register, bit 5 is the low-speed enable and bit 4 the high-speed enable. These are the only stored bits; bits 7:6 and 3:0 read 0 and ignore writes.
- R9: The status register (address 3) reads internal/low/high ready in bits 0/1/2 and 0 in bits 7:3. Writes to it change no register.
- R10: The internal oscillator has no stabilization wait. Its ready flag follows its enable bit after the synchronizer delay.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, all domains |
| int_clk | input | 1 | Internal oscillator clock |
| lo_clk | input | 1 | Low-speed oscillator clock |
| hi_clk | input | 1 | High-speed oscillator clock |
| sys_sel | input | 2 | Source currently driving the system clock (3 = none) |
| reg_addr | input | 2 | Register address |
| reg_we | input | 1 | Write strobe, sampled on `clk` |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Combinational read data for `reg_addr` |
| src_ready | output | 3 | Synchronized ready flags {high, low, internal} |

## Verification
The bench builds the block with `LO_WAIT`=16, `HI_WAIT_BASE`=64 and `HI_ON_RST`=1. With these values, every high-speed wait select (64/32/16/8 cycles), the low-speed wait and the restart after a disable can each be timed inside a short run. The high-speed source is running at reset, so the reset-time wait is checked as well. The source clocks have periods unrelated to the system clock, so ready latencies are checked against windows derived from the wait lengths. Register contents are compared against a behavioural model on every system clock.

// File: rtl/clksrc_pkg.sv
package clksrc_pkg;

  localparam int NSRC = 3;

  typedef enum logic [1:0] {
    SRC_INT  = 2'd0,
    SRC_LO   = 2'd1,
    SRC_HI   = 2'd2,
    SRC_NONE = 2'd3
  } src_sel_e;

  typedef enum logic [1:0] {
    RA_ENABLE  = 2'd0,
    RA_WAITEN  = 2'd1,
    RA_WAITSEL = 2'd2,
    RA_STATUS  = 2'd3
  } reg_addr_e;

  localparam int WEN_LO_BIT = 5;
  localparam int WEN_HI_BIT = 4;

  // High-speed stabilization length for a given select code.
  function automatic int unsigned hi_wait_len(input logic [1:0] s, input int unsigned base);
    return base >> s;
  endfunction

  // Apply the stop guard: the selected source may not lose its enable.
  function automatic logic [2:0] guard_enable(input logic [2:0] cur,
                                              input logic [2:0] req,
                                              input logic [1:0] sel);
    logic [2:0] r;
    r = req;
    for (int i = 0; i < NSRC; i++)
      if (sel == 2'(i)) r[i] = req[i] | cur[i];
    return r;
  endfunction

endpackage

// File: rtl/clksrc_sync2.sv
module clksrc_sync2 (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic meta;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta <= 1'b0;
      q    <= 1'b0;
    end else begin
      meta <= d;
      q    <= meta;
    end
  end
endmodule

// File: rtl/clksrc_stab.sv
module clksrc_stab #(
  parameter int CW = 11
) (
  input  logic          src_clk,
  input  logic          rst_n,
  input  logic          en_async,
  input  logic          wait_en,
  input  logic [CW-1:0] limit,
  output logic          rdy
);
  logic          en_s;
  logic [CW-1:0] cnt;
  logic          cnt_done;

  clksrc_sync2 u_en_sync (
    .clk  (src_clk),
    .rst_n(rst_n),
    .d    (en_async),
    .q    (en_s)
  );

  assign cnt_done = (cnt == limit - CW'(1));

  always_ff @(posedge src_clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
      rdy <= 1'b0;
    end else if (!en_s) begin
      cnt <= '0;
      rdy <= 1'b0;
    end else if (!rdy) begin
      if (!wait_en || cnt_done) rdy <= 1'b1;
      else                      cnt <= cnt + CW'(1);
    end
  end
endmodule

// File: rtl/clk_src_ctrl.sv
module clk_src_ctrl #(
  parameter int          LO_WAIT      = 256,
  parameter int          HI_WAIT_BASE = 1024,
  parameter bit          HI_ON_RST    = 1'b1
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       int_clk,
  input  logic       lo_clk,
  input  logic       hi_clk,
  input  logic [1:0] sys_sel,
  input  logic [1:0] reg_addr,
  input  logic       reg_we,
  input  logic [7:0] reg_wdata,
  output logic [7:0] reg_rdata,
  output logic [2:0] src_ready
);
  import clksrc_pkg::*;

  localparam int WMAX = (LO_WAIT > HI_WAIT_BASE) ? LO_WAIT : HI_WAIT_BASE;
  localparam int CW   = $clog2(WMAX + 1);

  logic [2:0]    en_q;
  logic [1:0]    wen_q;     // [1] low-speed, [0] high-speed
  logic [1:0]    wsel_q;
  logic          en_write;
  logic [2:0]    en_next;
  logic [2:0]    src_clk_v;
  logic [2:0]    wait_v;
  logic [CW-1:0] lim_v [NSRC];
  logic [2:0]    rdy_src;

  assign en_write = reg_we && (reg_addr == RA_ENABLE);
  assign en_next  = guard_enable(en_q, reg_wdata[2:0], sys_sel);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q   <= {HI_ON_RST, 1'b0, 1'b1};
      wen_q  <= 2'b11;
      wsel_q <= 2'b00;
    end else if (reg_we) begin
      case (reg_addr)
        RA_ENABLE:  en_q   <= en_next;
        RA_WAITEN:  wen_q  <= {reg_wdata[WEN_LO_BIT], reg_wdata[WEN_HI_BIT]};
        RA_WAITSEL: wsel_q <= reg_wdata[1:0];
        default: ;
      endcase
    end
  end

  assign src_clk_v = {hi_clk, lo_clk, int_clk};
  assign wait_v    = {wen_q[0], wen_q[1], 1'b0};
  assign lim_v[0]  = CW'(1);
  assign lim_v[1]  = CW'(LO_WAIT);
  assign lim_v[2]  = CW'(hi_wait_len(wsel_q, HI_WAIT_BASE));

  for (genvar g = 0; g < NSRC; g++) begin : g_src
    clksrc_stab #(.CW(CW)) u_stab (
      .src_clk (src_clk_v[g]),
      .rst_n   (rst_n),
      .en_async(en_q[g]),
      .wait_en (wait_v[g]),
      .limit   (lim_v[g]),
      .rdy     (rdy_src[g])
    );
    clksrc_sync2 u_rdy_sync (
      .clk  (clk),
      .rst_n(rst_n),
      .d    (rdy_src[g]),
      .q    (src_ready[g])
    );
  end

  always_comb begin
    case (reg_addr)
      RA_ENABLE:  reg_rdata = {5'b0, en_q};
      RA_WAITEN:  reg_rdata = {2'b0, wen_q, 4'b0};
      RA_WAITSEL: reg_rdata = {6'b0, wsel_q};
      default:    reg_rdata = {5'b0, src_ready};
    endcase
  end
endmodule

// File: rtl/clk_src_ctrl_chk.sv
module clk_src_ctrl_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [1:0] sys_sel,
  input logic [1:0] reg_addr,
  input logic       reg_we,
  input logic [7:0] reg_wdata,
  input logic [7:0] reg_rdata,
  input logic [2:0] en_q,
  input logic [1:0] wen_q,
  input logic       en_write
);
  for (genvar k = 0; k < 3; k++) begin : g_guard
    a_r2_selected_kept: assert property (@(posedge clk) disable iff (!rst_n)
      (en_write && sys_sel == 2'(k) && en_q[k]) |=> en_q[k]);
  end

  a_r3_free_write: assert property (@(posedge clk) disable iff (!rst_n)
    (en_write && sys_sel == 2'd3) |=> (en_q == $past(reg_wdata[2:0])));

  a_r8_reserved_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_addr == 2'd1) |-> (reg_rdata[7:6] == 2'b0 && reg_rdata[3:0] == 4'b0));

  a_r9_status_ro: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_we && reg_addr == 2'd3) |=> ($stable(en_q) && $stable(wen_q)));

  a_r9_status_upper: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_addr == 2'd3) |-> (reg_rdata[7:3] == 5'b0));
endmodule

bind clk_src_ctrl clk_src_ctrl_chk u_chk (.*);

// File: tb/clk_src_ctrl_test.sv
module clk_src_ctrl_test;
  localparam int LOW = 16;
  localparam int HIB = 64;
  localparam int PS  = 8;   // 125 MHz
  localparam int PI  = 10;
  localparam int PL  = 30;
  localparam int PH  = 6;

  logic clk = 0, int_clk = 0, lo_clk = 0, hi_clk = 0;
  logic rst_n = 0;
  logic [1:0] sys_sel = 0, reg_addr = 0;
  logic reg_we = 0;
  logic [7:0] reg_wdata = 0;
  logic [7:0] reg_rdata;
  logic [2:0] src_ready;

  int errors = 0, checks = 0;
  bit done = 0;

  always #(PS/2) clk = ~clk;
  always #(PI/2) int_clk = ~int_clk;
  always #(PL/2) lo_clk = ~lo_clk;
  always #(PH/2) hi_clk = ~hi_clk;

  clk_src_ctrl #(.LO_WAIT(LOW), .HI_WAIT_BASE(HIB), .HI_ON_RST(1'b1)) uut (
    .clk(clk), .rst_n(rst_n), .int_clk(int_clk), .lo_clk(lo_clk), .hi_clk(hi_clk),
    .sys_sel(sys_sel), .reg_addr(reg_addr), .reg_we(reg_we), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .src_ready(src_ready));

  // behavioural register model
  logic [2:0] m_en;
  logic [7:0] m_wen;
  logic [1:0] m_sel;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_en <= 3'b101; m_wen <= 8'h30; m_sel <= 2'd0;
    end else if (reg_we) begin
      if (reg_addr == 2'd0) begin
        logic [2:0] t;
        t = reg_wdata[2:0];
        if (sys_sel == 2'd0 && m_en[0]) t[0] = 1'b1;
        if (sys_sel == 2'd1 && m_en[1]) t[1] = 1'b1;
        if (sys_sel == 2'd2 && m_en[2]) t[2] = 1'b1;
        m_en <= t;
      end else if (reg_addr == 2'd1) m_wen <= reg_wdata & 8'h30;
      else if (reg_addr == 2'd2)     m_sel <= reg_wdata[1:0];
    end
  end

  task automatic check_eq(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h at %0t", tag, act, exp, $time);
    end
  endtask

  always @(posedge clk) begin
    #2;
    if (rst_n && !done)
      case (reg_addr)
        2'd0: check_eq("R2/R3 model enable", reg_rdata, {5'b0, m_en});
        2'd1: check_eq("R8 model wait-enable", reg_rdata, m_wen);
        2'd2: check_eq("R5 model wait-select", reg_rdata, {6'b0, m_sel});
        default: ;
      endcase
  end

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk); reg_addr = a; reg_wdata = d; reg_we = 1;
    @(negedge clk); reg_we = 0;
  endtask

  task automatic rd(input logic [1:0] a, input string tag, input logic [7:0] exp);
    @(negedge clk); reg_addr = a; #1;
    check_eq(tag, reg_rdata, exp);
  endtask

  task automatic stat_bit(input int b, input logic exp, input string tag);
    @(negedge clk); reg_addr = 2'd3; #1;
    check_eq(tag, {7'b0, reg_rdata[b]}, {7'b0, exp});
    check_eq({tag, " port"}, {7'b0, src_ready[b]}, {7'b0, exp});
  endtask

  task automatic setsel(input logic [1:0] s);
    @(negedge clk); sys_sel = s;
  endtask

  initial begin
    #1_000_000;
    errors++; checks++;
    $display("FAIL watchdog: got timeout expected completion");
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    check_eq("R1 ready at reset", {5'b0, src_ready}, 8'h00);
    rst_n = 1;
    rd(2'd0, "R1 enable reset", 8'h05);
    rd(2'd1, "R1 wait-enable reset", 8'h30);
    rd(2'd2, "R1 wait-select reset", 8'h00);
    #1000;
    rd(2'd3, "R10 R5 status after reset wait", 8'h05);

    // R4: low-speed wait
    wr(2'd0, 8'h07);
    #(LOW*PL - 10);
    stat_bit(1, 1'b0, "R4 low not yet ready");
    #(4*PL + 50);
    stat_bit(1, 1'b1, "R4 low ready");

    // R2: low-speed selected, try to stop everything
    setsel(2'd1);
    wr(2'd0, 8'h00);
    rd(2'd0, "R2 low kept on", 8'h02);
    #(3*PL + 60);
    stat_bit(2, 1'b0, "R7 high ready dropped");
    stat_bit(0, 1'b0, "R10 internal ready dropped");
    stat_bit(1, 1'b1, "R2 low still ready");

    // R5 / R7: each high-speed select, restart each time
    for (int s = 1; s < 4; s++) begin
      wr(2'd2, 8'(s));
      wr(2'd0, 8'h06);
      #((HIB >> s)*PH - 10);
      stat_bit(2, 1'b0, "R5 high not yet ready");
      #(4*PH + 50);
      stat_bit(2, 1'b1, "R5 high ready");
      wr(2'd0, 8'h02);
      #(3*PH + 60);
      stat_bit(2, 1'b0, "R7 high dropped");
    end

    // R6: bypass high-speed wait
    wr(2'd2, 8'h00);
    wr(2'd1, 8'h20);
    wr(2'd0, 8'h06);
    #(4*PH + 50);
    stat_bit(2, 1'b1, "R6 bypass ready");

    // R8: reserved bits
    wr(2'd1, 8'hFF);
    rd(2'd1, "R8 reserved masked", 8'h30);

    // R3: nothing selected, everything can stop
    setsel(2'd3);
    wr(2'd0, 8'h00);
    rd(2'd0, "R3 free write", 8'h00);
    #(3*PL + 60);
    rd(2'd3, "R7 all ready dropped", 8'h00);

    // R9: status is read-only
    wr(2'd3, 8'hFF);
    rd(2'd0, "R9 enable untouched", 8'h00);
    rd(2'd1, "R9 wait-enable untouched", 8'h30);
    rd(2'd3, "R9 status unchanged", 8'h00);

    // R7: low-speed restart after disable
    wr(2'd0, 8'h02);
    #(LOW*PL - 10);
    stat_bit(1, 1'b0, "R7 low restart waits");
    #(4*PL + 50);
    stat_bit(1, 1'b1, "R7 low ready again");

    // R2: internal selected
    wr(2'd0, 8'h03);
    setsel(2'd0);
    wr(2'd0, 8'h00);
    rd(2'd0, "R2 internal kept on", 8'h01);
    #(3*PI + 60);
    stat_bit(0, 1'b1, "R10 internal ready");

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule